// File: doc/BRIEF.md
# Registered-Output Iterative Unsigned Divider

This block divides one unsigned integer by another and returns the quotient and the remainder. It uses a radix-2 restoring algorithm and resolves one quotient bit per clock cycle, starting from the most significant bit. The operand width is a parameter and must be at least 2. An operation enters through a valid/ready handshake. The result leaves through a second valid/ready handshake. The unit holds one operation at a time.

The governing rule is timing isolation. Every output port, handshake outputs included, is driven only by flip-flops. No combinational path runs from any input to any output. A holding register keeps the operation in flight: its partial remainder, its partial quotient (which starts as the dividend and shifts left), the divisor, and a count of the quotient bits already resolved. A separate register flags the unit as empty. The output valid is itself a register. It is loaded through a lookahead predicate that reports whether the state will be complete after a given number of further steps. The predicate is true when the count is at least the larger of zero and the width minus that number of steps.

Top module: `divfsm_top`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is applied, and on the cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 after that edge.
- R3: For a nonzero divisor, `out_quotient` equals dividend / divisor and `out_remainder` equals dividend mod divisor, both unsigned.
- R4: `out_valid` goes to 1 exactly WIDTH rising edges after the accepting edge, for every operand pair, the zero divisor included.
- R5: A zero divisor gives a quotient with every bit set to 1 and a remainder equal to the dividend.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_quotient` and `out_remainder` stay unchanged across clock edges.
- R7: After a rising edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R8: While an operation is in flight, `in_valid` and new operand values are ignored. `in_ready` stays 0 and the delivered result is the one for the accepted operands.
- R9: No output port changes between clock edges. Changing `in_valid`, `out_ready`, `in_dividend` or `in_divisor` partway through a cycle leaves every output as it was.
- R10: `out_valid` and `in_ready` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on the input bus are offered |
| in_ready | output | 1 | Unit is empty and will take an operation (a register) |
| in_dividend | input | WIDTH | Unsigned dividend |
| in_divisor | input | WIDTH | Unsigned divisor |
| out_valid | output | 1 | Result is complete (a register) |
| out_ready | input | 1 | Downstream takes the result |
| out_quotient | output | WIDTH | Quotient, held in a register |
| out_remainder | output | WIDTH | Remainder, held in a register |

## Verification
The bench runs a 4-bit instance through every operand pair and computes each expected quotient and remainder with ordinary integer division. The pairs include a zero divisor, a divisor larger than the dividend, and both operands at their maximum. A design with an off-by-one bit count would report completion a cycle early or late, or drop the last quotient bit. A design that mishandled a zero divisor would show a wrong quotient or a lost remainder. Partway through cycles, the bench toggles the handshakes and the operand bus and watches that every output stays frozen. Any leak from the input side to the output side shows up there, as does a valid that is not registered. On some runs it holds back `out_ready` and offers junk operands while the unit is busy. A unit that let the result drift, released it too early, or took the junk operands would deliver a wrong or moving result.

// File: rtl/divfsm_pkg.sv
package divfsm_pkg;

  // True when a state with bits_known resolved quotient bits will be
  // complete after a further `steps` iteration steps.
  function automatic bit will_be_done_after(input int unsigned bits_known,
                                            input int unsigned width,
                                            input int unsigned steps);
    int unsigned floor_v;
    floor_v = (steps >= width) ? 0 : (width - steps);
    return bits_known >= floor_v;
  endfunction

  // Count register width for a given quotient width.
  function automatic int unsigned count_bits(input int unsigned width);
    return $clog2(width + 1);
  endfunction

endpackage

// File: rtl/divfsm_step.sv
// One restoring step: shift in the next dividend bit, then try the subtraction.
module divfsm_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rem_cur,
  input  logic [WIDTH-1:0] quo_cur,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] rem_next,
  output logic [WIDTH-1:0] quo_next,
  output logic             q_bit
);
  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0] shifted;
  logic [EXT-1:0] trial;

  always_comb begin
    shifted  = {rem_cur, quo_cur[WIDTH-1]};
    trial    = shifted - {1'b0, divisor};
    q_bit    = (shifted >= {1'b0, divisor});
    rem_next = q_bit ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    quo_next = {quo_cur[WIDTH-2:0], q_bit};
  end

endmodule

// File: rtl/divfsm_ctrl.sv
// Control: empty flag, resolved-bit count and registered output valid.
module divfsm_ctrl
  import divfsm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic empty_q,
  output logic valid_q,
  output logic accept_evt,
  output logic step_evt,
  output logic release_evt
);
  localparam int CW = count_bits(WIDTH);

  logic [CW-1:0] cnt_q;
  logic          done_now;
  logic          done_soon;

  always_comb begin
    done_now    = will_be_done_after(32'(cnt_q), WIDTH, 0);
    done_soon   = will_be_done_after(32'(cnt_q), WIDTH, 1);
    accept_evt  = in_valid & empty_q;
    step_evt    = ~empty_q & ~done_now;
    release_evt = valid_q & out_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (accept_evt) begin
      empty_q <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (step_evt) begin
      cnt_q   <= cnt_q + CW'(1);
      valid_q <= done_soon;
    end else if (release_evt) begin
      empty_q <= 1'b1;
      valid_q <= 1'b0;
    end
  end

  // R4: the lookahead-loaded valid agrees with "not empty and complete"
  p_valid_lookahead_r4: assert property (@(posedge clk) disable iff (rst)
    valid_q == (~empty_q & done_now));

  // R4: the count never passes the quotient width
  p_count_cap_r4: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) <= WIDTH);

  // R8: no acceptance while an operation is in flight
  p_busy_no_accept_r8: assert property (@(posedge clk) disable iff (rst)
    ~empty_q |-> ~accept_evt);

endmodule

// File: rtl/divfsm_datapath.sv
// Holding register for remainder, shifting quotient and divisor.
module divfsm_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] ld_dividend,
  input  logic [WIDTH-1:0] ld_divisor,
  output logic [WIDTH-1:0] rem_q,
  output logic [WIDTH-1:0] quo_q
);
  logic [WIDTH-1:0] div_q;
  logic [WIDTH-1:0] rem_nx;
  logic [WIDTH-1:0] quo_nx;
  logic             q_bit;

  divfsm_step #(.WIDTH(WIDTH)) u_step (
    .rem_cur (rem_q),
    .quo_cur (quo_q),
    .divisor (div_q),
    .rem_next(rem_nx),
    .quo_next(quo_nx),
    .q_bit   (q_bit)
  );

  always_ff @(posedge clk) begin
    if (load) begin
      rem_q <= '0;
      quo_q <= ld_dividend;
      div_q <= ld_divisor;
    end else if (step) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
    end
  end

  // R3: the partial remainder stays below a nonzero divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && div_q != '0) |=> rem_q < div_q);

  // R5: a zero divisor always resolves a one bit
  p_zero_div_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && div_q == '0) |-> q_bit);

endmodule

// File: rtl/divfsm_top.sv
module divfsm_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_dividend,
  input  logic [WIDTH-1:0] in_divisor,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_quotient,
  output logic [WIDTH-1:0] out_remainder
);
  logic empty_q;
  logic valid_q;
  logic accept_evt;
  logic step_evt;
  logic release_evt;
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] quo_q;

  divfsm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .empty_q    (empty_q),
    .valid_q    (valid_q),
    .accept_evt (accept_evt),
    .step_evt   (step_evt),
    .release_evt(release_evt)
  );

  divfsm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load       (accept_evt),
    .step       (step_evt),
    .ld_dividend(in_dividend),
    .ld_divisor (in_divisor),
    .rem_q      (rem_q),
    .quo_q      (quo_q)
  );

  // Every port below comes straight from a flip-flop.
  assign in_ready      = empty_q;
  assign out_valid     = valid_q;
  assign out_quotient  = quo_q;
  assign out_remainder = rem_q;

  // R1: reset leaves the unit empty with no result
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid));

  // R2: acceptance closes the input side
  p_accept_closes_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R6: result held under backpressure
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_quotient) && $stable(out_remainder)));

  // R7: a taken result empties the unit
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R10: the two handshake outputs never overlap
  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && in_ready));

endmodule

// File: tb/divfsm_top_tb.sv
module divfsm_top_tb;
  localparam int  W = 4;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_dividend;
  logic [W-1:0] in_divisor;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_quotient;
  logic [W-1:0] out_remainder;

  int total = 0;
  int bad   = 0;

  divfsm_top #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quotient(out_quotient), .out_remainder(out_remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R9: wiggle inputs mid-cycle and confirm no output moves
  task automatic isolation_probe();
    logic [2*W+1:0] snap;
    logic           sv_iv, sv_or;
    logic [W-1:0]   sv_a, sv_b;
    snap  = {in_ready, out_valid, out_quotient, out_remainder};
    sv_iv = in_valid; sv_or = out_ready; sv_a = in_dividend; sv_b = in_divisor;
    in_valid = ~in_valid; out_ready = ~out_ready;
    in_dividend = ~in_dividend; in_divisor = in_divisor + 4'd5;
    #1;
    chk(snap == {in_ready, out_valid, out_quotient, out_remainder}, "R9",
        "outputs moved between edges",
        int'({in_ready, out_valid, out_quotient, out_remainder}), int'(snap));
    in_valid = sv_iv; out_ready = sv_or; in_dividend = sv_a; in_divisor = sv_b;
  endtask

  task automatic run_div(input int a, input int b, input int mode);
    int lat;
    int exp_q, exp_r;
    bit hold, junk;
    hold = (mode != 0);
    junk = (mode == 1);
    if (b == 0) begin exp_q = (1 << W) - 1; exp_r = a; end
    else begin exp_q = a / b; exp_r = a % b; end

    chk(in_ready == 1'b1, "R2", "in_ready before offer", int'(in_ready), 1);
    in_valid = 1'b1; in_dividend = W'(a); in_divisor = W'(b);
    out_ready = !hold;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2", "in_ready after accept", int'(in_ready), 0);
    if (junk) begin
      // R8: junk offer while busy
      in_dividend = W'(a + 7); in_divisor = W'(b + 3);
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (!out_valid && lat < W + 4) begin
      isolation_probe();
      chk(!(out_valid && in_ready), "R10", "valid and ready together",
          int'(out_valid), 0);
      if (junk) chk(in_ready == 1'b0, "R8", "in_ready while busy", int'(in_ready), 0);
      @(negedge clk);
      lat++;
    end
    chk(lat == W, "R4", "latency in edges", lat, W);
    chk(in_ready == 1'b0, "R10", "in_ready with result", int'(in_ready), 0);
    if (b == 0) begin
      chk(int'(out_quotient) == exp_q, "R5", "zero-divisor quotient", int'(out_quotient), exp_q);
      chk(int'(out_remainder) == exp_r, "R5", "zero-divisor remainder", int'(out_remainder), exp_r);
    end else begin
      chk(int'(out_quotient) == exp_q, junk ? "R8" : "R3", "quotient", int'(out_quotient), exp_q);
      chk(int'(out_remainder) == exp_r, junk ? "R8" : "R3", "remainder", int'(out_remainder), exp_r);
    end
    if (hold) begin
      for (int k = 0; k < 2; k++) begin
        isolation_probe();
        @(negedge clk);
        chk(out_valid == 1'b1, "R6", "valid held", int'(out_valid), 1);
        chk(int'(out_quotient) == exp_q && int'(out_remainder) == exp_r, "R6",
            "result held", int'({out_quotient, out_remainder}),
            int'({W'(exp_q), W'(exp_r)}));
      end
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid after take", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7", "ready after take", int'(in_ready), 1);
    out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0; out_ready = 1'b0; in_dividend = '0; in_divisor = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready under reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid under reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_div(a, b, (a + b) % 3);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule